// File: doc/BRIEF.md
# Conversion Sequence Status Tracker

This block follows an analog-to-digital converter as it works through a sequence of result slots, and it keeps the status bits that software polls to see how far the sequence has got. A start strobe, which is the write to the sequence-control register, begins a sequence at slot zero. Each done pulse from the converter core marks one finished conversion. The block sets the completion flag of the slot that was just converted and moves its pointer to the next slot. Once a whole pass has finished, a sequence-complete flag is raised.

The block is configured by five inputs. One selects a sequence length of four or eight slots. One selects a single pass or continuous scanning. One selects how flags are cleared: either by the next start, or by reading the matching result register (fast clear). One enables special mode, in which the flags can be written directly. The last carries the per-slot result-read strobes. The block drives a run output, so the converter core knows whether it should go on converting.

Top module: `adc_seq_status`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the sequence-complete flag, the 3-bit slot pointer, all eight slot flags and the run output are 0.
- R2: A done pulse is accepted only while run is 1 and no start strobe is present. An accepted pulse sets the slot flag whose index equals the pointer, and the pointer then advances by one, modulo the sequence length, on the next clock.
- R3: When the length input is 0, the sequence has four slots. The pointer then wraps from 3 to 0, and slot flags 4 to 7 are never set by conversions.
- R4: In single-pass mode (scan input 0), the done pulse for the last slot drops run and sets the sequence-complete flag. Further done pulses leave the pointer and all flags unchanged until the next start strobe.
- R5: In continuous mode (scan input 1), run stays at 1 and the pointer keeps wrapping. The sequence-complete flag is set only at the end of the first pass after a start; later pass ends do not set it again.
- R6: A start strobe always sets the pointer to 0 and run to 1. With fast clear off, it also clears the sequence-complete flag and all slot flags.
- R7: With fast clear on, a start strobe leaves the sequence-complete flag and the slot flags unchanged.
- R8: With fast clear on, a read strobe on result i clears slot flag i, and a read strobe on result 0 also clears the sequence-complete flag. With fast clear off, read strobes have no effect.
- R9: With special mode on, a flag write loads the sequence-complete flag and the slot flags from the write data. With special mode off, a flag write has no effect.
- R10: When an accepted done pulse sets a flag, that set wins over a clear or a write to the same flag in the same cycle.
- R11: A done pulse in the same cycle as a start strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_wr | input | 1 | Start strobe (sequence-control write) |
| conv_done | input | 1 | One-cycle done pulse from the converter core |
| len_full | input | 1 | 1 selects eight slots, 0 selects four |
| scan_mode | input | 1 | 1 selects continuous scanning |
| fast_clr | input | 1 | 1 makes result reads clear the flags |
| special_mode | input | 1 | 1 makes the flags writable |
| rslt_rd | input | 8 | Per-result read strobes |
| flag_wr | input | 1 | Flag write strobe |
| wr_seq | input | 1 | Write data for the sequence-complete flag |
| wr_cc | input | 8 | Write data for the slot flags |
| seq_done | output | 1 | Sequence-complete flag |
| conv_cnt | output | 3 | Pointer to the slot being converted |
| cc_flags | output | 8 | Per-slot completion flags |
| conv_run | output | 1 | Converter should keep converting |

## Verification
The bench sweeps every combination of length, scan mode and fast-clear mode. In each combination it sends more done pulses than the sequence has slots. This shows the wrap point of four against eight slots, the stop-and-ignore behaviour of single-pass mode against continued wrapping in continuous mode, and whether a start clears or keeps the flags. Read strobes are applied under both clear modes to show the difference between a clear and no effect. Directed cycles then combine a set with a read, a set with a write, and a done pulse with a start, to check the priority of each pair.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef int unsigned uint_t;

  // number of slots in one pass for the selected length
  function automatic uint_t slot_count(logic len_full, uint_t nslot);
    return len_full ? nslot : nslot / 2;
  endfunction

  // pointer is at (or beyond) the final slot of the pass
  function automatic logic is_last_slot(uint_t ptr, uint_t slots);
    return ptr >= slots - 1;
  endfunction

  // pointer value after an accepted conversion
  function automatic uint_t ptr_step(uint_t ptr, uint_t slots);
    return is_last_slot(ptr, slots) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/adc_status_bit.sv
module adc_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic q_o
);
  // priority: hardware set, then special write, then clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (wr_en_i) q_o <= wr_val_i;
    else if (clr_i)   q_o <= 1'b0;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int CNT_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             conv_done,
  input  logic             len_full,
  input  logic             scan_mode,
  output logic [CNT_W-1:0] ptr_o,
  output logic             run_o,
  output logic             evt_conv_o,
  output logic             evt_pass_end_o,
  output logic             evt_seq_set_o
);
  logic  first_pass;
  uint_t slots;

  assign slots          = slot_count(len_full, uint_t'(NSLOT));
  assign evt_conv_o     = conv_done & run_o & ~start_wr;
  assign evt_pass_end_o = evt_conv_o & is_last_slot(uint_t'(ptr_o), slots);
  assign evt_seq_set_o  = evt_pass_end_o & first_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_o      <= '0;
      run_o      <= 1'b0;
      first_pass <= 1'b0;
    end else if (start_wr) begin
      ptr_o      <= '0;
      run_o      <= 1'b1;
      first_pass <= 1'b1;
    end else if (evt_conv_o) begin
      ptr_o <= CNT_W'(ptr_step(uint_t'(ptr_o), slots));
      if (evt_pass_end_o) begin
        first_pass <= 1'b0;
        if (!scan_mode) run_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status #(
  parameter int NSLOT = 8,
  parameter int CNT_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             conv_done,
  input  logic             len_full,
  input  logic             scan_mode,
  input  logic             fast_clr,
  input  logic             special_mode,
  input  logic [NSLOT-1:0] rslt_rd,
  input  logic             flag_wr,
  input  logic             wr_seq,
  input  logic [NSLOT-1:0] wr_cc,
  output logic             seq_done,
  output logic [CNT_W-1:0] conv_cnt,
  output logic [NSLOT-1:0] cc_flags,
  output logic             conv_run
);
  // named internal events, visible to the checker
  logic             evt_conv;
  logic             evt_pass_end;
  logic             evt_seq_set;
  logic             clr_on_start;
  logic             flag_wr_en;
  logic [NSLOT-1:0] cc_set;
  logic [NSLOT-1:0] cc_clr;
  logic             seq_clr;

  adc_seq_ctrl #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_wr       (start_wr),
    .conv_done      (conv_done),
    .len_full       (len_full),
    .scan_mode      (scan_mode),
    .ptr_o          (conv_cnt),
    .run_o          (conv_run),
    .evt_conv_o     (evt_conv),
    .evt_pass_end_o (evt_pass_end),
    .evt_seq_set_o  (evt_seq_set)
  );

  assign clr_on_start = start_wr & ~fast_clr;
  assign flag_wr_en   = special_mode & flag_wr;
  assign seq_clr      = clr_on_start | (fast_clr & rslt_rd[0]);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign cc_set[i] = evt_conv & (conv_cnt == CNT_W'(i));
    assign cc_clr[i] = clr_on_start | (fast_clr & rslt_rd[i]);

    adc_status_bit u_cc (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (cc_set[i]),
      .clr_i    (cc_clr[i]),
      .wr_en_i  (flag_wr_en),
      .wr_val_i (wr_cc[i]),
      .q_o      (cc_flags[i])
    );
  end

  adc_status_bit u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_seq_set),
    .clr_i    (seq_clr),
    .wr_en_i  (flag_wr_en),
    .wr_val_i (wr_seq),
    .q_o      (seq_done)
  );
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk #(
  parameter int NSLOT = 8,
  parameter int CNT_W = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_wr,
  input logic             conv_done,
  input logic             len_full,
  input logic             scan_mode,
  input logic             fast_clr,
  input logic             special_mode,
  input logic [NSLOT-1:0] rslt_rd,
  input logic             flag_wr,
  input logic             seq_done,
  input logic [CNT_W-1:0] conv_cnt,
  input logic [NSLOT-1:0] cc_flags,
  input logic             conv_run,
  input logic             evt_pass_end
);
  logic accept;
  assign accept = conv_done & conv_run & ~start_wr;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (conv_cnt == '0 && cc_flags == '0 && !seq_done && !conv_run));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> conv_cnt == CNT_W'((32'($past(conv_cnt)) + 1) %
                                  ($past(len_full) ? NSLOT : NSLOT / 2)));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cc_flags[$past(conv_cnt)]);

  a_r3_short_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !len_full && conv_cnt < CNT_W'(NSLOT / 2)) |=> conv_cnt < CNT_W'(NSLOT / 2));

  a_r4_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pass_end && !scan_mode) |=> (!conv_run && seq_done));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_run && !start_wr && !(special_mode && flag_wr) && rslt_rd == '0)
      |=> ($stable(conv_cnt) && $stable(cc_flags) && $stable(seq_done)));

  a_r5_scan_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_run && scan_mode) |=> conv_run);

  a_r6_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !fast_clr && !(special_mode && flag_wr))
      |=> (conv_cnt == '0 && conv_run && cc_flags == '0 && !seq_done));

  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && !accept && !(special_mode && flag_wr))
      |=> (cc_flags & $past(rslt_rd)) == '0);
endmodule

bind adc_seq_status adc_seq_status_chk #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_wr     (start_wr),
  .conv_done    (conv_done),
  .len_full     (len_full),
  .scan_mode    (scan_mode),
  .fast_clr     (fast_clr),
  .special_mode (special_mode),
  .rslt_rd      (rslt_rd),
  .flag_wr      (flag_wr),
  .seq_done     (seq_done),
  .conv_cnt     (conv_cnt),
  .cc_flags     (cc_flags),
  .conv_run     (conv_run),
  .evt_pass_end (evt_pass_end)
);

// File: tb/tb_adc_seq_status.sv
`timescale 1ns/1ps
module tb_adc_seq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_wr = 1'b0, conv_done = 1'b0;
  logic       len_full = 1'b1, scan_mode = 1'b0, fast_clr = 1'b0, special_mode = 1'b0;
  logic [7:0] rslt_rd = '0;
  logic       flag_wr = 1'b0, wr_seq = 1'b0;
  logic [7:0] wr_cc = '0;
  logic       seq_done, conv_run;
  logic [2:0] conv_cnt;
  logic [7:0] cc_flags;

  // bench-side expectation
  logic [2:0] m_cnt = '0;
  logic [7:0] m_cc = '0;
  logic       m_seq = 1'b0, m_run = 1'b0, m_first = 1'b0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  adc_seq_status dut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .conv_done(conv_done),
    .len_full(len_full), .scan_mode(scan_mode), .fast_clr(fast_clr),
    .special_mode(special_mode), .rslt_rd(rslt_rd), .flag_wr(flag_wr),
    .wr_seq(wr_seq), .wr_cc(wr_cc), .seq_done(seq_done), .conv_cnt(conv_cnt),
    .cc_flags(cc_flags), .conv_run(conv_run)
  );

  task automatic cmp(string tag);
    checks++;
    if ({seq_done, conv_cnt, cc_flags, conv_run} !== {m_seq, m_cnt, m_cc, m_run}) begin
      fails++;
      $display("FAIL %s: got seq=%0b cnt=%0d cc=%02h run=%0b exp seq=%0b cnt=%0d cc=%02h run=%0b",
               tag, seq_done, conv_cnt, cc_flags, conv_run, m_seq, m_cnt, m_cc, m_run);
    end
  endtask

  task automatic step(string tag, bit st, bit dn, logic [7:0] rd, bit wr, bit wseq, logic [7:0] wcc);
    int   len;
    bit   acc, wipe, we;
    logic [7:0] ncc;
    logic nseq;
    @(negedge clk);
    start_wr = st; conv_done = dn; rslt_rd = rd; flag_wr = wr; wr_seq = wseq; wr_cc = wcc;
    len  = len_full ? 8 : 4;
    acc  = dn && m_run && !st;
    wipe = st && !fast_clr;
    we   = special_mode && wr;
    for (int i = 0; i < 8; i++) begin
      if (acc && int'(m_cnt) == i)     ncc[i] = 1'b1;
      else if (we)                     ncc[i] = wcc[i];
      else if (wipe || (fast_clr && rd[i])) ncc[i] = 1'b0;
      else                             ncc[i] = m_cc[i];
    end
    if (acc && int'(m_cnt) == len - 1 && m_first) nseq = 1'b1;
    else if (we)                                  nseq = wseq;
    else if (wipe || (fast_clr && rd[0]))         nseq = 1'b0;
    else                                          nseq = m_seq;
    @(posedge clk);
    #1;
    start_wr = 1'b0; conv_done = 1'b0; rslt_rd = '0; flag_wr = 1'b0;
    m_cc = ncc; m_seq = nseq;
    if (st) begin
      m_cnt = '0; m_run = 1'b1; m_first = 1'b1;
    end else if (acc) begin
      if (int'(m_cnt) == len - 1) begin
        m_cnt = '0; m_first = 1'b0;
        if (!scan_mode) m_run = 1'b0;
      end else m_cnt = m_cnt + 3'd1;
    end
    cmp(tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    cmp("R1 during reset");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    cmp("R1 after reset");

    for (int lf = 0; lf < 2; lf++)
      for (int sc = 0; sc < 2; sc++)
        for (int fc = 0; fc < 2; fc++) begin
          int len;
          len_full = lf[0]; scan_mode = sc[0]; fast_clr = fc[0];
          len = lf ? 8 : 4;
          step(fc ? "R7 start" : "R6 start", 1, 0, '0, 0, 0, '0);
          for (int k = 0; k < len + 3; k++)
            step(k < len ? (lf ? "R2 convert" : "R3 convert") : (sc ? "R5 wrap" : "R4 ignore"),
                 0, 1, '0, 0, 0, '0);
          if (fc) begin
            step("R8 read slot0", 0, 0, 8'h01, 0, 0, '0);
            step("R8 read slots2-3", 0, 0, 8'h0C, 0, 0, '0);
          end else begin
            step("R8 read no effect", 0, 0, 8'hFF, 0, 0, '0);
          end
          for (int k = 0; k < len; k++)
            step(sc ? "R5 no re-set" : "R4 ignore", 0, 1, '0, 0, 0, '0);
          step(fc ? "R7 restart" : "R6 restart", 1, 0, '0, 0, 0, '0);
          step("R11 start with done", 1, 1, '0, 0, 0, '0);
          step("R2 first slot", 0, 1, '0, 0, 0, '0);
        end

    // special-mode writes
    len_full = 1'b1; scan_mode = 1'b0; fast_clr = 1'b0;
    special_mode = 1'b1;
    step("R9 special write", 0, 0, '0, 1, 1, 8'hA5);
    special_mode = 1'b0;
    step("R9 normal write ignored", 0, 0, '0, 1, 0, 8'h5A);

    // priority of set over clear and write
    fast_clr = 1'b1; scan_mode = 1'b1;
    step("R10 start", 1, 0, '0, 0, 0, '0);
    step("R10 set vs read", 0, 1, 8'h01, 0, 0, '0);
    special_mode = 1'b1;
    step("R10 set vs write", 0, 1, '0, 1, 0, 8'h00);
    special_mode = 1'b0;
    step("R8 read after set", 0, 0, 8'h03, 0, 0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule